// File: doc/BRIEF.md
# Serial Memory Identification-Page Lock Controller

This block is the slave-side command logic of a serial-peripheral memory that runs the one-time command making the identification page read-only for good. It watches chip select, serial clock and serial data input, oversampled by the system clock. It assembles each frame, keeps the write-enable latch and the two block-protect bits, and qualifies a lock request against all of them. A request that survives every check starts a self-timed write cycle, modelled by a counter of system clocks. When the count ends, a sticky lock flag is set.

A frame opens when chip select falls and closes when it rises. Bits are taken on rising serial-clock edges (clock idles low), most significant bit first. A lock frame is exactly one opcode byte, three address bytes and one data byte. The command runs only if chip select rises after the final data bit and before any further rising clock edge. A failing qualifier drops the request without any report. Three supporting commands exist only so the lock gate can be driven and observed: set write enable, write status and read status.

Top module: `idlock_ctrl`

## Requirements
- R1: After reset, wip and id_locked are 0, spi_miso_oe is 0, and a status read returns 0x00.
- R2: Opcode 0x05 (status read) returns, on falling clock edges after the opcode, the byte {3'b000, lock flag, bp[1], bp[0], write-enable latch, wip} MSB first. spi_miso_oe is high only during that output phase.
- R3: Opcode 0x06 framed as exactly 8 bits sets the write-enable latch. Opcode 0x01 framed as exactly 16 bits loads bp[1:0] from bits 3:2 of its data byte and clears the latch, but only when the latch is set; without it the frame is ignored.
- R4: Opcode 0x82, then a 24-bit address with bit 10 set, then a data byte with bit 1 set, ended after exactly 40 bits with the latch set, raises wip for WRITE_CYCLES clocks. After that, id_locked is 1 and the latch is 0. All other address and data bits are ignored.
- R5: A lock frame sent while the write-enable latch is clear does not start a write cycle.
- R6: A lock frame whose address bit 10 is 0 is discarded (no write cycle) and clears the latch.
- R7: A lock frame whose data bit 1 is 0 is discarded and clears the latch.
- R8: A lock frame ended after any bit count other than 40 (39, 41 or 48 bits) is discarded and clears the latch.
- R9: With bp = 2'b11 a lock frame is discarded and clears the latch.
- R10: A lock frame received during a write cycle is discarded and does not restart or lengthen the cycle.
- R11: id_locked stays 1 through later frames and write cycles, and only reset clears it.
- R12: spi_miso_oe stays 0 for the whole of a lock frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out (status read only) |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |
| wip | output | 1 | Self-timed write cycle in progress |
| id_locked | output | 1 | Sticky identification-page lock flag |

## Verification
The bench ends lock frames one bit early, one bit late and a whole byte late. A design that only checks byte alignment, or only a minimum length, would lock on the 48-bit frame. Frames with every other address and data bit set or cleared show that only bit 10 and bit 1 qualify; a decoder indexing the wrong bit would accept the wrong frame. A second lock frame inside a running write cycle, with the latch still set, shows whether the timer restarts: wip would then stay high far past its window. Status reads after every discard show whether the write-enable latch was cleared, as each discard rule requires.

// File: rtl/idlock_pkg.sv
package idlock_pkg;

   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_LOCK  = 8'h82;

   localparam int BYTE_BITS = 8;

   typedef struct packed {
      logic sclk_rise;
      logic sclk_fall;
      logic cs_fall;
      logic cs_rise;
      logic mosi;
      logic cs_held_low;
   } pin_evt_t;

endpackage

// File: rtl/idlock_frontend.sv
module idlock_frontend #(
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n_i,
   input  logic                 sclk_i,
   input  logic                 mosi_i,
   output idlock_pkg::pin_evt_t evt_o
);

   logic cs_s, sclk_s, mosi_s;
   logic cs_p, sclk_p;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs_s   = cs_n_i;
         assign sclk_s = sclk_i;
         assign mosi_s = mosi_i;
      end else begin : g_sync
         logic [2:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= 3'b100;
            end else begin
               pipe_q[0] <= {cs_n_i, sclk_i, mosi_i};
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign cs_s   = pipe_q[SYNC_STAGES-1][2];
         assign sclk_s = pipe_q[SYNC_STAGES-1][1];
         assign mosi_s = pipe_q[SYNC_STAGES-1][0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p   <= 1'b1;
         sclk_p <= 1'b0;
      end else begin
         cs_p   <= cs_s;
         sclk_p <= sclk_s;
      end
   end

   always_comb begin
      evt_o.sclk_rise   = sclk_s & ~sclk_p & ~cs_s;
      evt_o.sclk_fall   = ~sclk_s & sclk_p & ~cs_s;
      evt_o.cs_fall     = ~cs_s & cs_p;
      evt_o.cs_rise     = cs_s & ~cs_p;
      evt_o.mosi        = mosi_s;
      evt_o.cs_held_low = ~cs_p;
   end

endmodule

// File: rtl/idlock_decoder.sv
module idlock_decoder #(
   parameter int ADDR_BYTES     = 3,
   parameter int LOCK_ADDR_BIT  = 10,
   parameter int LOCK_DATA_BIT  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  idlock_pkg::pin_evt_t evt_i,
   input  logic [7:0]           status_i,
   input  logic                 wel_i,
   input  logic                 wip_i,
   input  logic [1:0]           bp_i,
   output logic                 set_wel_o,
   output logic                 bp_wr_o,
   output logic [1:0]           bp_val_o,
   output logic                 lock_start_o,
   output logic                 lock_drop_o,
   output logic                 miso_o,
   output logic                 miso_oe_o
);
   import idlock_pkg::*;

   localparam int FRAME_BITS  = BYTE_BITS * (ADDR_BYTES + 2);
   localparam int CNT_W       = $clog2(FRAME_BITS + BYTE_BITS + 1);
   localparam int IDX_W       = CNT_W - 3;
   localparam int CNT_MAX     = (1 << CNT_W) - 1;
   localparam int AFLAG_IDX   = ADDR_BYTES - (LOCK_ADDR_BIT / BYTE_BITS);
   localparam int AFLAG_POS   = LOCK_ADDR_BIT % BYTE_BITS;
   localparam int DATA_IDX    = ADDR_BYTES + 1;

   generate
      if (LOCK_ADDR_BIT >= ADDR_BYTES * BYTE_BITS) begin : g_bad_abit
         $error("LOCK_ADDR_BIT outside the address field");
      end
      if (LOCK_DATA_BIT > 7 || LOCK_DATA_BIT < 0) begin : g_bad_dbit
         $error("LOCK_DATA_BIT outside the data byte");
      end
      if (ADDR_BYTES < 1) begin : g_bad_abytes
         $error("ADDR_BYTES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] bit_cnt;
   logic [6:0]       sh_q;
   logic [7:0]       op_q;
   logic             aflag_q;
   logic             dflag_q;
   logic [1:0]       bpnew_q;
   logic [7:0]       tx_q;
   logic             oe_q;

   logic [7:0]       byte_now;
   logic [IDX_W-1:0] byte_idx;
   logic             byte_done;
   logic             op_known;
   logic             lock_ok;

   assign byte_now  = {sh_q, evt_i.mosi};
   assign byte_idx  = bit_cnt[CNT_W-1:3];
   assign byte_done = evt_i.sclk_rise && (bit_cnt[2:0] == 3'd7) && (bit_cnt != CNT_W'(CNT_MAX));
   assign op_known  = (bit_cnt >= CNT_W'(BYTE_BITS));

   assign lock_ok = (bit_cnt == CNT_W'(FRAME_BITS)) && aflag_q && dflag_q &&
                    wel_i && !wip_i && (bp_i != 2'b11);

   // frame assembly
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sh_q    <= '0;
         op_q    <= '0;
         aflag_q <= 1'b0;
         dflag_q <= 1'b0;
         bpnew_q <= '0;
      end else if (evt_i.cs_fall) begin
         bit_cnt <= '0;
         op_q    <= '0;
         aflag_q <= 1'b0;
         dflag_q <= 1'b0;
      end else if (evt_i.sclk_rise) begin
         sh_q <= byte_now[6:0];
         if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
         if (byte_done) begin
            if (byte_idx == '0) op_q <= byte_now;
            if (byte_idx == IDX_W'(1)) bpnew_q <= byte_now[3:2];
            if (byte_idx == IDX_W'(AFLAG_IDX)) aflag_q <= byte_now[AFLAG_POS];
            if (byte_idx == IDX_W'(DATA_IDX)) dflag_q <= byte_now[LOCK_DATA_BIT];
         end
      end
   end

   // status output shifter, updated on falling serial clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         oe_q <= 1'b0;
      end else if (evt_i.cs_rise || evt_i.cs_fall) begin
         oe_q <= 1'b0;
      end else if (evt_i.sclk_fall && op_known && (op_q == OP_RDSR)) begin
         oe_q <= 1'b1;
         if (bit_cnt[2:0] == 3'd0) tx_q <= status_i;
         else                      tx_q <= {tx_q[6:0], 1'b0};
      end
   end

   assign miso_o    = oe_q & tx_q[7];
   assign miso_oe_o = oe_q;

   // command execution at chip-select rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_wel_o    <= 1'b0;
         bp_wr_o      <= 1'b0;
         bp_val_o     <= '0;
         lock_start_o <= 1'b0;
         lock_drop_o  <= 1'b0;
      end else begin
         set_wel_o    <= 1'b0;
         bp_wr_o      <= 1'b0;
         lock_start_o <= 1'b0;
         lock_drop_o  <= 1'b0;
         if (evt_i.cs_rise && op_known && !wip_i) begin
            if (op_q == OP_WREN && bit_cnt == CNT_W'(BYTE_BITS))
               set_wel_o <= 1'b1;
            if (op_q == OP_WRSR && bit_cnt == CNT_W'(2*BYTE_BITS) && wel_i) begin
               bp_wr_o  <= 1'b1;
               bp_val_o <= bpnew_q;
            end
         end
         if (evt_i.cs_rise && op_known && op_q == OP_LOCK) begin
            if (lock_ok) lock_start_o <= 1'b1;
            else         lock_drop_o  <= 1'b1;
         end
      end
   end

   assert_oe_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe_o |-> evt_i.cs_held_low);

   assert_oe_only_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe_o |-> (op_q == OP_RDSR));

   assert_frame_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_start_o |-> $past(bit_cnt) == CNT_W'(FRAME_BITS));

endmodule

// File: rtl/idlock_state.sv
module idlock_state #(
   parameter int WRITE_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_wel_i,
   input  logic       bp_wr_i,
   input  logic [1:0] bp_val_i,
   input  logic       lock_start_i,
   input  logic       lock_drop_i,
   output logic       wel_o,
   output logic [1:0] bp_o,
   output logic       wip_o,
   output logic       locked_o
);

   localparam int WC_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

   generate
      if (WRITE_CYCLES < 1) begin : g_bad_wc
         $error("WRITE_CYCLES must be at least 1");
      end
   endgenerate

   logic [WC_W-1:0] timer_q;
   logic            done;

   assign done = wip_o && (timer_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer_q  <= '0;
         wip_o    <= 1'b0;
         locked_o <= 1'b0;
      end else if (lock_start_i && !wip_o) begin
         timer_q <= WC_W'(WRITE_CYCLES - 1);
         wip_o   <= 1'b1;
      end else if (done) begin
         wip_o    <= 1'b0;
         locked_o <= 1'b1;
      end else if (wip_o) begin
         timer_q <= timer_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_o <= 1'b0;
         bp_o  <= '0;
      end else begin
         if (bp_wr_i) bp_o <= bp_val_i;
         if (done || lock_drop_i || bp_wr_i) wel_o <= 1'b0;
         else if (set_wel_i)                 wel_o <= 1'b1;
      end
   end

   assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> locked_o);

   assert_start_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_start_i |-> wel_o);

   assert_start_not_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_start_i |-> (bp_o != 2'b11));

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_start_i |-> !wip_o);

   assert_wel_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip_o) |-> !wel_o && locked_o);

endmodule

// File: rtl/idlock_ctrl.sv
module idlock_ctrl #(
   parameter int SYNC_STAGES   = 2,
   parameter int ADDR_BYTES    = 3,
   parameter int LOCK_ADDR_BIT = 10,
   parameter int LOCK_DATA_BIT = 1,
   parameter int WRITE_CYCLES  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sclk,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe,
   output logic wip,
   output logic id_locked
);

   idlock_pkg::pin_evt_t evt;
   logic       set_wel, bp_wr, lock_start, lock_drop;
   logic [1:0] bp_val, bp;
   logic       wel;
   logic [7:0] status;

   assign status = {3'b000, id_locked, bp, wel, wip};

   idlock_frontend #(.SYNC_STAGES(SYNC_STAGES)) i_frontend (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n_i (spi_cs_n),
      .sclk_i (spi_sclk),
      .mosi_i (spi_mosi),
      .evt_o  (evt)
   );

   idlock_decoder #(
      .ADDR_BYTES    (ADDR_BYTES),
      .LOCK_ADDR_BIT (LOCK_ADDR_BIT),
      .LOCK_DATA_BIT (LOCK_DATA_BIT)
   ) i_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt),
      .status_i     (status),
      .wel_i        (wel),
      .wip_i        (wip),
      .bp_i         (bp),
      .set_wel_o    (set_wel),
      .bp_wr_o      (bp_wr),
      .bp_val_o     (bp_val),
      .lock_start_o (lock_start),
      .lock_drop_o  (lock_drop),
      .miso_o       (spi_miso),
      .miso_oe_o    (spi_miso_oe)
   );

   idlock_state #(.WRITE_CYCLES(WRITE_CYCLES)) i_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_wel_i    (set_wel),
      .bp_wr_i      (bp_wr),
      .bp_val_i     (bp_val),
      .lock_start_i (lock_start),
      .lock_drop_i  (lock_drop),
      .wel_o        (wel),
      .bp_o         (bp),
      .wip_o        (wip),
      .locked_o     (id_locked)
   );

endmodule

// File: tb/test_idlock_ctrl.sv
`timescale 1ns/1ps
module test_idlock_ctrl;

   localparam int WC   = 2000;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe, wip, id_locked;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;
   longint cyc = 0;
   longint t_end = 0;
   logic [63:0] rx;
   int oe_hi;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   idlock_ctrl #(.WRITE_CYCLES(WC)) i_idlock_ctrl (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .wip(wip), .id_locked(id_locked)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [63:0] bits, input int n);
      oe_hi = 0;
      rx = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         spi_mosi = bits[63-i];
         wait_clk(HALF);
         rx = {rx[62:0], spi_miso};
         if (spi_miso_oe) oe_hi++;
         spi_sclk = 1'b1;
         wait_clk(HALF);
         spi_sclk = 1'b0;
      end
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      t_end = cyc;
      wait_clk(2*HALF);
   endtask

   task automatic wren();
      frame({8'h06, 56'h0}, 8);
   endtask

   task automatic wrsr(input logic [7:0] d);
      frame({8'h01, d, 48'h0}, 16);
   endtask

   task automatic lock(input logic [23:0] a, input logic [7:0] d, input int n);
      frame({8'h82, a, d, 24'h0}, n);
   endtask

   task automatic expect_status(input logic [7:0] exp, input string req);
      frame({8'h05, 56'h0}, 16);
      check(rx[7:0] == exp, req, rx[7:0], exp);
   endtask

   task automatic wait_until(input longint t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic t_reset();
      check(wip == 1'b0, "R1 wip", wip, 0);
      check(id_locked == 1'b0, "R1 locked", id_locked, 0);
      check(spi_miso_oe == 1'b0, "R1 oe", spi_miso_oe, 0);
      expect_status(8'h00, "R1 status");
   endtask

   task automatic t_status_read();
      wren();
      expect_status(8'h02, "R2 wel visible");
      check(oe_hi == 8, "R2 oe samples", oe_hi, 8);
      check(spi_miso_oe == 1'b0, "R2 oe after frame", spi_miso_oe, 0);
   endtask

   task automatic t_wrsr();
      wrsr(8'h04);
      expect_status(8'h04, "R3 bp written, wel cleared");
      wrsr(8'h0C);
      expect_status(8'h04, "R3 ignored without wel");
      wren();
      wrsr(8'h00);
      expect_status(8'h00, "R3 bp cleared");
   endtask

   task automatic t_discards();
      lock(24'hABC400, 8'hF6, 40);
      wait_clk(20);
      check(wip == 1'b0, "R5 no wel no cycle", wip, 0);
      wren();
      lock(24'hFFFBFF, 8'hFF, 40);
      wait_clk(20);
      check(wip == 1'b0, "R6 addr bit clear", wip, 0);
      expect_status(8'h00, "R6 wel cleared");
      wren();
      lock(24'hFFFFFF, 8'hFD, 40);
      wait_clk(20);
      check(wip == 1'b0, "R7 data bit clear", wip, 0);
      expect_status(8'h00, "R7 wel cleared");
      wren();
      lock(24'h000400, 8'h02, 39);
      check(wip == 1'b0, "R8 39 bits", wip, 0);
      expect_status(8'h00, "R8 wel cleared 39");
      wren();
      lock(24'h000400, 8'h02, 41);
      check(wip == 1'b0, "R8 41 bits", wip, 0);
      wren();
      lock(24'h000400, 8'h02, 48);
      check(wip == 1'b0, "R8 48 bits", wip, 0);
      expect_status(8'h00, "R8 wel cleared 48");
   endtask

   task automatic t_protected();
      wren();
      wrsr(8'h0C);
      wren();
      lock(24'h000400, 8'h02, 40);
      wait_clk(20);
      check(wip == 1'b0, "R9 protected", wip, 0);
      expect_status(8'h0C, "R9 wel cleared");
      wren();
      wrsr(8'h00);
      check(id_locked == 1'b0, "R9 not locked", id_locked, 0);
   endtask

   task automatic t_lock_and_busy();
      longint t0;
      wren();
      lock(24'hABC400, 8'hF6, 40);
      t0 = t_end;
      check(oe_hi == 0, "R12 oe low in lock frame", oe_hi, 0);
      wait_until(t0 + 20);
      check(wip == 1'b1, "R4 wip started", wip, 1);
      lock(24'h000400, 8'h02, 40);
      wait_until(t0 + WC - 100);
      check(wip == 1'b1, "R4 wip still high", wip, 1);
      check(id_locked == 1'b0, "R4 not yet locked", id_locked, 0);
      wait_until(t0 + WC + 100);
      check(wip == 1'b0, "R10 no restart", wip, 0);
      check(id_locked == 1'b1, "R4 locked", id_locked, 1);
      expect_status(8'h10, "R4 wel cleared at end");
   endtask

   task automatic t_sticky();
      longint t0;
      wren();
      lock(24'h000400, 8'h02, 40);
      t0 = t_end;
      wait_until(t0 + 20);
      check(wip == 1'b1 && id_locked == 1'b1, "R11 lock kept in cycle", {wip, id_locked}, 3);
      wait_until(t0 + WC + 100);
      check(id_locked == 1'b1, "R11 lock kept after", id_locked, 1);
      @(negedge clk);
      rst_n = 1'b0;
      wait_clk(4);
      check(id_locked == 1'b0, "R11 reset clears", id_locked, 0);
      rst_n = 1'b1;
      wait_clk(4);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_status_read();
      t_wrsr();
      t_discards();
      t_protected();
      t_lock_and_busy();
      t_sticky();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule